// File: doc/BRIEF.md
# Flash Program/Erase Status Tracker

This block stands in for the internal sequencer that runs program and erase cycles inside a serial NOR flash. It also holds the flag byte that a host polls to follow that sequencer. Decoded one-cycle strobes arrive from a command front end: program, erase, suspend, resume and clear-flags. Alongside them come two qualifiers, `prot_hit` and `supply_fault`, which describe the target of a new operation. A `vfy_ok` level comes from an abstract array model and is read at the end of every pulse.

An operation runs as a series of fixed-length pulses. Each pulse lasts `PULSE_CYC` cycles, and its verify result is read on its last cycle. A passing verify ends the operation. When a pulse fails verify and it was the last one allowed, the operation ends with an error flag. A suspend strobe marks the suspend flag at once, but the sequencer keeps pulsing through a latency window. It halts only when that window runs out, and if the operation completes first it does not halt at all. The busy indication is available in two forms of opposite polarity: the ready bit of the flag byte and a separate write-in-progress output.

Top module: `pes_status_tracker`

## Requirements
- R1: After reset `flag_status` is 0x80 and `wip` is 0. The bit fields of the byte are: [7] ready, [6] erase suspended, [5] erase error, [4] program error, [3] supply error, [2] program suspended, [1] protection error. Bit [0] always reads 0.
- R2: `flag_status[7]` is always the inverse of `wip`. Both change one cycle after the edge that starts an operation, completes it, suspends it or resumes it.
- R3: An accepted erase runs pulses of `PULSE_CYC` cycles. It becomes ready in the cycle after the last cycle of the first pulse whose verify passes. With defaults, a pass on pulse k (k counted from 1) gives ready 4·k cycles after the erase strobe.
- R4: If all `MAX_ERASE` erase pulses fail verify, the erase ends and sets bit 5. With defaults this happens 32 cycles after the strobe.
- R5: A program or erase accepted while `prot_hit` is high does not start. It sets bit 1 together with bit 4 (program) or bit 5 (erase), and `wip` stays 0.
- R6: A program uses the same pulse loop with a limit of `MAX_PROG` pulses. It becomes ready after the first passing pulse, or sets bit 4 when all `MAX_PROG` pulses fail (16 cycles with defaults).
- R7: A program or erase accepted while `supply_fault` is high (and `prot_hit` is low) does not start. It sets bit 3 together with bit 4 or bit 5.
- R8: A suspend strobe during an erase sets bit 6 in the next cycle while `wip` stays 1. `SUSP_LAT` cycles after that strobe edge the byte reads 0xC0. The pulse position then stays frozen for as long as the suspension lasts.
- R9: If the operation completes inside the suspend latency, it ends as a normal completion: bits 6 and 2 clear, and ready sets.
- R10: A resume strobe while suspended clears bits 6 and 2 and drops ready. Pulsing then continues from the frozen position.
- R11: A suspend strobe during a program behaves as in R8 but uses bit 2 in place of bit 6.
- R12: Bits 5, 4, 3 and 1 hold until a clear-flags strobe arrives while ready is 1. Clear-flags while busy has no effect.
- R13: Some strobes are ignored and leave the byte unchanged: suspend while idle, resume while not suspended, and program or erase while busy or suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_prog | input | 1 | Program strobe |
| cmd_erase | input | 1 | Erase strobe (wins over program if both) |
| cmd_susp | input | 1 | Suspend strobe |
| cmd_resume | input | 1 | Resume strobe |
| cmd_clr | input | 1 | Clear error flags strobe |
| prot_hit | input | 1 | Target of the new command is protected |
| supply_fault | input | 1 | Programming supply out of range for the new command |
| vfy_ok | input | 1 | Verify result, read on the last cycle of each pulse |
| flag_status | output | 8 | Registered flag byte |
| wip | output | 1 | Registered write-in-progress, inverse of flag_status[7] |

## Verification
The hardest states to reach from the ports are those where a suspend meets a pulse boundary. One is an erase that finishes inside the suspend latency. Another is a suspended erase that must restart from the middle of a pulse. The bench places the suspend strobe one cycle after the erase strobe and holds the verify level to choose which outcome occurs. It then times the resume to the cycle so that the remaining pulse length shows the frozen position.

// File: rtl/pes_pkg.sv
package pes_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SUSP} ctl_st_e;

  localparam int FB_READY  = 7;
  localparam int FB_ESUSP  = 6;
  localparam int FB_EERR   = 5;
  localparam int FB_PERR   = 4;
  localparam int FB_SUPPLY = 3;
  localparam int FB_PSUSP  = 2;
  localparam int FB_PROT   = 1;

  localparam logic [7:0] ERR_MASK = 8'b0011_1010;
  localparam logic [7:0] RST_FLAGS = 8'h80;
endpackage

// File: rtl/pes_pulse_seq.sv
module pes_pulse_seq #(
  parameter int PULSE_CYC = 4,
  parameter int MAX_ERASE = 8,
  parameter int MAX_PROG  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_erase,
  input  logic advance,
  input  logic vfy_ok,
  output logic pass_now,
  output logic fail_now
);
  localparam int MAXP = (MAX_ERASE > MAX_PROG) ? MAX_ERASE : MAX_PROG;
  localparam int TW   = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam int PW   = (MAXP > 1) ? $clog2(MAXP) : 1;

  logic [TW-1:0] tcnt;
  logic [PW-1:0] pcnt;
  logic          erase_op;
  logic [PW-1:0] limit;
  logic          pulse_end;

  assign limit     = erase_op ? PW'(MAX_ERASE - 1) : PW'(MAX_PROG - 1);
  assign pulse_end = advance && (tcnt == TW'(PULSE_CYC - 1));
  assign pass_now  = pulse_end && vfy_ok;
  assign fail_now  = pulse_end && !vfy_ok && (pcnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt     <= '0;
      pcnt     <= '0;
      erase_op <= 1'b0;
    end else if (start) begin
      tcnt     <= '0;
      pcnt     <= '0;
      erase_op <= start_erase;
    end else if (advance) begin
      if (pulse_end) begin
        tcnt <= '0;
        if (!vfy_ok && (pcnt != limit)) pcnt <= pcnt + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pes_susp_timer.sv
module pes_susp_timer #(
  parameter int SUSP_LAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic cancel,
  output logic pending,
  output logic expire
);
  localparam int LW = (SUSP_LAT > 1) ? $clog2(SUSP_LAT) : 1;

  logic [LW-1:0] cnt;

  assign expire = pending && (cnt == LW'(SUSP_LAT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (cancel) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (arm) begin
      pending <= 1'b1;
      cnt     <= '0;
    end else if (expire) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (pending) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pes_flag_reg.sv
module pes_flag_reg #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              q[i] <= RST_VAL[i];
      else if (set_mask[i]) q[i] <= 1'b1;
      else if (clr_mask[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pes_status_tracker.sv
module pes_status_tracker
  import pes_pkg::*;
#(
  parameter int PULSE_CYC = 4,
  parameter int MAX_ERASE = 8,
  parameter int MAX_PROG  = 4,
  parameter int SUSP_LAT  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_prog,
  input  logic       cmd_erase,
  input  logic       cmd_susp,
  input  logic       cmd_resume,
  input  logic       cmd_clr,
  input  logic       prot_hit,
  input  logic       supply_fault,
  input  logic       vfy_ok,
  output logic [7:0] flag_status,
  output logic       wip
);
  ctl_st_e    st;
  logic       op_erase;
  logic       accept, start, done, susp_arm, take_susp, resume;
  logic       pass_now, fail_now, pending, expire;
  logic [7:0] set_m, clr_m;

  assign accept    = (st == ST_IDLE) && (cmd_prog || cmd_erase);
  assign start     = accept && !prot_hit && !supply_fault;
  assign done      = pass_now || fail_now;
  assign susp_arm  = (st == ST_RUN) && cmd_susp && !pending && !done;
  assign take_susp = expire && !done;
  assign resume    = (st == ST_SUSP) && cmd_resume;

  pes_pulse_seq #(
    .PULSE_CYC(PULSE_CYC),
    .MAX_ERASE(MAX_ERASE),
    .MAX_PROG (MAX_PROG)
  ) u_pulse (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_erase(cmd_erase),
    .advance    (st == ST_RUN),
    .vfy_ok     (vfy_ok),
    .pass_now   (pass_now),
    .fail_now   (fail_now)
  );

  pes_susp_timer #(.SUSP_LAT(SUSP_LAT)) u_susp (
    .clk    (clk),
    .rst    (rst),
    .arm    (susp_arm),
    .cancel (done),
    .pending(pending),
    .expire (expire)
  );

  always_comb begin
    set_m = '0;
    clr_m = '0;
    if (cmd_clr && (st != ST_RUN)) clr_m = clr_m | ERR_MASK;
    if (accept && prot_hit) begin
      set_m[FB_PROT] = 1'b1;
      if (cmd_erase) set_m[FB_EERR] = 1'b1;
      else           set_m[FB_PERR] = 1'b1;
    end else if (accept && supply_fault) begin
      set_m[FB_SUPPLY] = 1'b1;
      if (cmd_erase) set_m[FB_EERR] = 1'b1;
      else           set_m[FB_PERR] = 1'b1;
    end
    if (start) clr_m[FB_READY] = 1'b1;
    if (susp_arm) begin
      if (op_erase) set_m[FB_ESUSP] = 1'b1;
      else          set_m[FB_PSUSP] = 1'b1;
    end
    if (done) begin
      set_m[FB_READY] = 1'b1;
      clr_m[FB_ESUSP] = 1'b1;
      clr_m[FB_PSUSP] = 1'b1;
      if (fail_now) begin
        if (op_erase) set_m[FB_EERR] = 1'b1;
        else          set_m[FB_PERR] = 1'b1;
      end
    end
    if (take_susp) set_m[FB_READY] = 1'b1;
    if (resume) begin
      clr_m[FB_READY] = 1'b1;
      clr_m[FB_ESUSP] = 1'b1;
      clr_m[FB_PSUSP] = 1'b1;
    end
  end

  pes_flag_reg #(.W(8), .RST_VAL(RST_FLAGS)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_mask(set_m),
    .clr_mask(clr_m),
    .q       (flag_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      op_erase <= 1'b0;
      wip      <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st       <= ST_RUN;
          op_erase <= cmd_erase;
          wip      <= 1'b1;
        end
        ST_RUN: if (done) begin
          st  <= ST_IDLE;
          wip <= 1'b0;
        end else if (take_susp) begin
          st  <= ST_SUSP;
          wip <= 1'b0;
        end
        ST_SUSP: if (resume) begin
          st  <= ST_RUN;
          wip <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pes_status_tracker_chk.sv
module pes_status_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_prog,
  input logic       cmd_erase,
  input logic       cmd_susp,
  input logic       cmd_resume,
  input logic       cmd_clr,
  input logic       prot_hit,
  input logic [7:0] flag_status,
  input logic       wip
);
  localparam logic [7:0] ERRS = 8'b0011_1010;

  p_ready_inverse_r2: assert property (@(posedge clk) disable iff (rst)
    flag_status[7] == !wip);

  p_reserved_low_r1: assert property (@(posedge clk) disable iff (rst)
    flag_status[0] == 1'b0);

  p_susp_flag_busy_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_status[6]) |-> $past(wip));

  p_resume_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_status[7] && (flag_status[6] || flag_status[2]) && cmd_resume)
    |=> (!flag_status[7] && !flag_status[6] && !flag_status[2]));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (wip || !cmd_clr)
    |=> ((flag_status & $past(flag_status) & ERRS) == ($past(flag_status) & ERRS)));

  p_idle_susp_ignored_r13: assert property (@(posedge clk) disable iff (rst)
    (!wip && !flag_status[6] && !flag_status[2] && cmd_susp)
    |=> (!flag_status[6] && !flag_status[2]));

  p_prot_no_start_r5: assert property (@(posedge clk) disable iff (rst)
    (!wip && !flag_status[6] && !flag_status[2] && (cmd_prog || cmd_erase) && prot_hit)
    |=> (!wip && flag_status[1]));
endmodule

bind pes_status_tracker pes_status_tracker_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_prog   (cmd_prog),
  .cmd_erase  (cmd_erase),
  .cmd_susp   (cmd_susp),
  .cmd_resume (cmd_resume),
  .cmd_clr    (cmd_clr),
  .prot_hit   (prot_hit),
  .flag_status(flag_status),
  .wip        (wip)
);

// File: tb/pes_status_tracker_test.sv
`timescale 1ns/1ps
module pes_status_tracker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_prog = 0, cmd_erase = 0, cmd_susp = 0, cmd_resume = 0, cmd_clr = 0;
  logic prot_hit = 0, supply_fault = 0, vfy_ok = 0;
  logic [7:0] flag_status;
  logic wip;
  int total = 0;
  int bad = 0;
  int n;

  always #2 clk = ~clk;

  pes_status_tracker uut (
    .clk(clk), .rst(rst), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
    .cmd_susp(cmd_susp), .cmd_resume(cmd_resume), .cmd_clr(cmd_clr),
    .prot_hit(prot_hit), .supply_fault(supply_fault), .vfy_ok(vfy_ok),
    .flag_status(flag_status), .wip(wip)
  );

  // {erase, prot, supply, vfy, cycles to ready, expected flags}
  localparam logic [19:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 8'd4,  8'h80},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd32, 8'hA0},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'd4,  8'h80},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd16, 8'h90},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'd0,  8'hA2},
    {1'b0, 1'b1, 1'b0, 1'b1, 8'd0,  8'h92},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'd0,  8'hA8},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  8'h98}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2, 3: return "R6";
      4, 5: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive a one-cycle strobe; returns at the negedge after the sampling edge.
  task automatic strobe(input int which);
    case (which)
      0: cmd_prog = 1;
      1: cmd_erase = 1;
      2: cmd_susp = 1;
      3: cmd_resume = 1;
      default: cmd_clr = 1;
    endcase
    @(negedge clk);
    cmd_prog = 0; cmd_erase = 0; cmd_susp = 0; cmd_resume = 0; cmd_clr = 0;
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    while (!flag_status[7] && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset flags", flag_status, 8'h80);
    chk("R2 reset wip", wip, 0);

    // Table of single operations
    for (int i = 0; i < 8; i++) begin
      strobe(4);
      chk("R12 clear before vector", flag_status, 8'h80);
      prot_hit = VEC[i][18];
      supply_fault = VEC[i][17];
      vfy_ok = VEC[i][16];
      strobe(VEC[i][19] ? 1 : 0);
      prot_hit = 0;
      supply_fault = 0;
      if (VEC[i][15:8] != 0) chk({vec_tag(i), " busy after start R2"}, wip, 1);
      wait_ready(n);
      chk({vec_tag(i), " cycles"}, n, int'(VEC[i][15:8]));
      chk({vec_tag(i), " flags"}, flag_status, VEC[i][7:0]);
    end

    // Sticky errors, clear ignored while busy (R12)
    strobe(4);
    vfy_ok = 0;
    strobe(1);
    wait_ready(n);
    chk("R4 erase fail flags", flag_status, 8'hA0);
    vfy_ok = 1;
    strobe(1);
    strobe(4);
    wait_ready(n);
    chk("R12 clear while busy ignored", flag_status, 8'hA0);
    strobe(4);
    chk("R12 clear when ready", flag_status, 8'h80);

    // New command rejected while busy (R13)
    vfy_ok = 1;
    strobe(1);
    prot_hit = 1;
    strobe(0);
    prot_hit = 0;
    wait_ready(n);
    chk("R13 busy reject timing", n, 3);
    chk("R13 busy reject flags", flag_status, 8'h80);

    // Erase passing on third pulse (R3)
    vfy_ok = 0;
    strobe(1);
    repeat (8) @(negedge clk);
    vfy_ok = 1;
    repeat (3) @(negedge clk);
    chk("R3 still busy before third pulse end", wip, 1);
    @(negedge clk);
    chk("R3 ready after third pulse", flag_status, 8'h80);

    // Erase suspend, freeze, reject, resume (R8, R10, R13)
    vfy_ok = 0;
    strobe(1);
    strobe(2);
    chk("R8 suspend flag immediate", flag_status, 8'h40);
    repeat (3) @(negedge clk);
    chk("R8 latency still busy", flag_status, 8'h40);
    @(negedge clk);
    chk("R8 suspended flags", flag_status, 8'hC0);
    chk("R8 suspended wip", wip, 0);
    repeat (10) @(negedge clk);
    chk("R8 suspension holds", flag_status, 8'hC0);
    prot_hit = 1;
    strobe(0);
    prot_hit = 0;
    chk("R13 reject while suspended", flag_status, 8'hC0);
    vfy_ok = 1;
    strobe(3);
    chk("R10 resume clears", flag_status, 8'h00);
    @(negedge clk);
    chk("R10 frozen pulse continues", wip, 1);
    @(negedge clk);
    chk("R10 frozen pulse continues 2", wip, 1);
    @(negedge clk);
    chk("R10 finishes remaining pulse", flag_status, 8'h80);

    // Idle suspend/resume ignored (R13)
    strobe(2);
    chk("R13 suspend idle ignored", flag_status, 8'h80);
    strobe(3);
    chk("R13 resume idle ignored", flag_status, 8'h80);

    // Completion inside suspend latency (R9)
    vfy_ok = 1;
    strobe(1);
    strobe(2);
    chk("R9 suspend flag set", flag_status, 8'h40);
    repeat (2) @(negedge clk);
    chk("R9 still in latency", flag_status, 8'h40);
    @(negedge clk);
    chk("R9 completes normally", flag_status, 8'h80);
    repeat (3) @(negedge clk);
    chk("R9 no late suspend", flag_status, 8'h80);

    // Program suspend (R11)
    vfy_ok = 0;
    strobe(0);
    strobe(2);
    chk("R11 program suspend flag", flag_status, 8'h04);
    repeat (4) @(negedge clk);
    chk("R11 program suspended", flag_status, 8'h84);
    vfy_ok = 1;
    strobe(3);
    chk("R11 program resume", flag_status, 8'h00);
    repeat (3) @(negedge clk);
    chk("R11 program done", flag_status, 8'h80);
    chk("R2 wip idle at end", wip, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule